// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block is the address-phase front end of an I2C slave. It takes received bits one at a time, MSB first, each marked by a strobe. Bus start and stop events are separate inputs. The block compares the address carried by the first byte, or by the first two bytes, against a programmed own address. A five-bit mask can turn selected low address bits into don't-cares, so a single slave answers to a whole group of addresses. When the address matches, the block drives the acknowledge for the matching byte. On the final matching byte it also raises a one-cycle interrupt and a sticky match flag. It keeps the address that was actually received, so software can tell which address of the group was used.

A mode input selects the addressing scheme:

- **7-bit mode:** one byte is compared.
- **10-bit mode:** a fixed header byte carries the two top address bits and must match exactly. The second byte then holds the low eight address bits, and those are compared under the mask.

The controller has six states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waits for a start event. |
| `ST_FIRST` | Shifts in the first byte. |
| `ST_ACK_MID` | Acknowledge slot after a matching 10-bit header. |
| `ST_LOW` | Shifts in the low byte of a 10-bit address. |
| `ST_ACK_FIN` | Acknowledge slot after the final matching byte. |
| `ST_DONE` | Holds the match until the bus is released. |

Its transitions are:

- A start event moves any state to `ST_FIRST`.
- A stop event moves any state to `ST_IDLE`. A stop event wins over a start event in the same cycle.
- From `ST_FIRST`, a completed byte goes to one of three states:
  - `ST_ACK_FIN` for a 7-bit match.
  - `ST_ACK_MID` for a 10-bit header match.
  - `ST_IDLE` on a mismatch.
- `ST_ACK_MID` moves to `ST_LOW` on the next bit strobe.
- From `ST_LOW`, a completed byte goes to `ST_ACK_FIN` on a match and to `ST_IDLE` on a mismatch.
- `ST_ACK_FIN` moves to `ST_DONE` on the next bit strobe.

Top module: `i2c_masked_addr_filter`

## Requirements
- R1: In 7-bit mode the received byte's bits 7:1 are compared with `own_addr[7:1]`. For k = 0..4, `addr_mask[k]` = 1 makes address bit k+1 a don't-care. Bits 7 and 6 are always compared.
- R2: In 7-bit mode the received bit 0 (R/W) is never compared. Bit 0 and bits 9:8 of `own_addr` have no effect on the result.
- R3: In 10-bit mode the first byte must equal `11110`, then `own_addr[9:8]`, then any R/W bit, MSB first. No mask applies to it. A match is acknowledged, and a mismatch ends the transaction.
- R4: In 10-bit mode the second byte is compared with `own_addr[7:0]`. For k = 1..4, `addr_mask[k]` masks bit k+1. `addr_mask[0]` masks bits 1 and 0 together. Bits 7:6 are always compared.
- R5: `ack` goes high in the cycle after the strobe of the eighth bit of a matching byte. It stays high until the cycle after the next bit strobe (the acknowledge slot), and then falls.
- R6: After a mismatching byte, `ack` stays low and all further bits are ignored until the next start event.
- R7: When the final address byte matches, `match_irq` is high for exactly one cycle. It rises together with `match_flag` and `ack`.
- R8: A start or stop event clears `match_flag` in the next cycle and restarts bit counting. A stop event also drops `ack` and returns the block to idle.
- R9: On a final match the received address is captured. 7-bit mode stores `{3'b000, byte[7:1]}`; 10-bit mode stores `{header[2:1], low byte}`. `rx_rw` takes the R/W bit of the first byte. Both hold until the next final match.
- R10: During and after reset, `ack`, `match_irq`, `match_flag`, `rx_addr` and `rx_rw` are all 0.
- R11: With `addr_mask` = 0, only the exact own address is accepted in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | Start or repeated-start event, one cycle |
| stop_evt | input | 1 | Stop event, one cycle |
| bit_valid | input | 1 | Strobe: `bit_val` holds a received bit |
| bit_val | input | 1 | Received bit value, MSB first |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| own_addr | input | 10 | Programmed own address |
| addr_mask | input | 5 | Don't-care mask for the low address bits |
| ack | output | 1 | Acknowledge drive for the current slot |
| match_irq | output | 1 | One-cycle pulse on a final address match |
| match_flag | output | 1 | Set on a match, cleared on start or stop |
| rx_addr | output | 10 | Address actually received on the last match |
| rx_rw | output | 1 | R/W bit of the last matching transaction |

## Verification
The vector table drives many address bytes against a few own-address and mask settings.

- **Mask edges:** each masked case is paired with a byte that differs in a bit just outside the mask. This separates correct mask positioning from a mask that is off by one bit.
- **Always-compared bits:** full-mask cases flip bits 7:6. They show whether the top two bits stay compared.
- **10-bit mask bit 0:** cases with `addr_mask[0]` alone set distinguish the 10-bit rule, where that bit covers bits 1 and 0, from the 7-bit rule, where it covers bit 1 only.
- **10-bit header:** header bytes with a wrong prefix or wrong top bits check that the header is matched exactly and without the mask.
- **Sequencing:** directed cases check the following:
  - bits after a mismatch are ignored;
  - a start mid-byte restarts the byte;
  - a stop ends the acknowledge;
  - a long wait before the acknowledge strobe leaves `ack` held high.

// File: rtl/i2c_amf_pkg.sv
package i2c_amf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_ACK_MID,
        ST_LOW,
        ST_ACK_FIN,
        ST_DONE
    } amf_state_e;

endpackage

// File: rtl/i2c_amf_shifter.sv
module i2c_amf_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_now
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] hist_q;
    logic [CNT_W-1:0]  cnt_q;

    // The byte as it stands with the current bit appended.
    assign byte_now  = {hist_q, bit_in};
    assign byte_done = shift_en && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else if (shift_en) begin
            hist_q <= byte_now[BYTE_W-2:0];
            cnt_q  <= byte_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_amf_cmp.sv
module i2c_amf_cmp #(
    parameter int BYTE_W = 8,
    parameter int MASK_W = 5,
    parameter int ADDR_W = 10
) (
    input  logic [BYTE_W-1:0] byte_now,
    input  logic              is_ten,
    input  logic              low_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    localparam int HI_W  = ADDR_W - BYTE_W;
    localparam int TAG_W = BYTE_W - 1 - HI_W;
    localparam logic [TAG_W-1:0] HDR_TAG = {{(TAG_W-1){1'b1}}, 1'b0};

    logic [BYTE_W-1:0] care_short;
    logic [BYTE_W-1:0] care_long;
    logic [BYTE_W-1:0] diff;
    logic              hit_short;
    logic              hit_long;
    logic              hit_hdr;

    // Per-bit compare enables for the two masking rules.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_care
        if (i == 0) begin : g_lsb
            assign care_short[i] = 1'b0;
            assign care_long[i]  = ~mask[0];
        end else if (i <= MASK_W) begin : g_masked
            assign care_short[i] = ~mask[i-1];
            assign care_long[i]  = ~mask[i-1];
        end else begin : g_fixed
            assign care_short[i] = 1'b1;
            assign care_long[i]  = 1'b1;
        end
    end

    assign diff      = byte_now ^ own_addr[BYTE_W-1:0];
    assign hit_short = ~|(diff & care_short);
    assign hit_long  = ~|(diff & care_long);
    assign hit_hdr   = (byte_now[BYTE_W-1 -: TAG_W] == HDR_TAG) &&
                       (byte_now[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);

    always_comb begin
        if (!is_ten)       hit = hit_short;
        else if (low_byte) hit = hit_long;
        else               hit = hit_hdr;
    end
endmodule

// File: rtl/i2c_amf_ctrl.sv
module i2c_amf_ctrl
    import i2c_amf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_valid,
    input  logic              mode_10b,
    input  logic              byte_done,
    input  logic              hit,
    input  logic [BYTE_W-1:0] byte_now,
    output logic              shift_en,
    output logic              low_byte,
    output logic              ack,
    output logic              match_irq,
    output logic              match_flag,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              rx_rw
);
    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam int SHORT_W = BYTE_W - 1;

    amf_state_e state_q, state_d;
    logic [HI_W-1:0] hdr_hi_q;
    logic            hdr_rw_q;
    logic            final_hit;
    logic            hdr_hit;

    assign shift_en  = bit_valid && !start_evt && !stop_evt &&
                       (state_q == ST_FIRST || state_q == ST_LOW);
    assign low_byte  = (state_q == ST_LOW);
    assign ack       = (state_q == ST_ACK_MID) || (state_q == ST_ACK_FIN);
    assign hdr_hit   = byte_done && hit && (state_q == ST_FIRST) && mode_10b;
    assign final_hit = byte_done && hit &&
                       ((state_q == ST_LOW) || (state_q == ST_FIRST && !mode_10b));

    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_FIRST;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_FIRST:   if (byte_done)
                                state_d = !hit ? ST_IDLE
                                        : (mode_10b ? ST_ACK_MID : ST_ACK_FIN);
                ST_ACK_MID: if (bit_valid) state_d = ST_LOW;
                ST_LOW:     if (byte_done) state_d = hit ? ST_ACK_FIN : ST_IDLE;
                ST_ACK_FIN: if (bit_valid) state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_irq  <= 1'b0;
            match_flag <= 1'b0;
            rx_addr    <= '0;
            rx_rw      <= 1'b0;
            hdr_hi_q   <= '0;
            hdr_rw_q   <= 1'b0;
        end else begin
            match_irq <= 1'b0;
            if (start_evt || stop_evt) begin
                match_flag <= 1'b0;
            end else if (hdr_hit) begin
                hdr_hi_q <= byte_now[HI_W:1];
                hdr_rw_q <= byte_now[0];
            end else if (final_hit) begin
                match_irq  <= 1'b1;
                match_flag <= 1'b1;
                if (mode_10b) begin
                    rx_addr <= {hdr_hi_q, byte_now};
                    rx_rw   <= hdr_rw_q;
                end else begin
                    rx_addr <= {{(ADDR_W-SHORT_W){1'b0}}, byte_now[BYTE_W-1:1]};
                    rx_rw   <= byte_now[0];
                end
            end
        end
    end
endmodule

// File: rtl/i2c_masked_addr_filter.sv
module i2c_masked_addr_filter #(
    parameter int BYTE_W = 8,
    parameter int MASK_W = 5,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bit_valid,
    input  logic              bit_val,
    input  logic              mode_10b,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [MASK_W-1:0] addr_mask,
    output logic              ack,
    output logic              match_irq,
    output logic              match_flag,
    output logic [ADDR_W-1:0] rx_addr,
    output logic              rx_rw
);
    logic              shift_en;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_now;
    logic              low_byte;
    logic              hit;

    i2c_amf_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start_evt || stop_evt),
        .shift_en  (shift_en),
        .bit_in    (bit_val),
        .byte_done (byte_done),
        .byte_now  (byte_now)
    );

    i2c_amf_cmp #(.BYTE_W(BYTE_W), .MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_cmp (
        .byte_now (byte_now),
        .is_ten   (mode_10b),
        .low_byte (low_byte),
        .own_addr (own_addr),
        .mask     (addr_mask),
        .hit      (hit)
    );

    i2c_amf_ctrl #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .bit_valid  (bit_valid),
        .mode_10b   (mode_10b),
        .byte_done  (byte_done),
        .hit        (hit),
        .byte_now   (byte_now),
        .shift_en   (shift_en),
        .low_byte   (low_byte),
        .ack        (ack),
        .match_irq  (match_irq),
        .match_flag (match_flag),
        .rx_addr    (rx_addr),
        .rx_rw      (rx_rw)
    );
endmodule

// File: rtl/i2c_amf_checker.sv
module i2c_amf_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_evt,
    input logic              stop_evt,
    input logic              bit_valid,
    input logic              mode_10b,
    input logic              ack,
    input logic              match_irq,
    input logic              match_flag,
    input logic [ADDR_W-1:0] rx_addr
);
    p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !bit_valid && !start_evt && !stop_evt |=> ack);

    p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack && bit_valid && !start_evt && !stop_evt |=> !ack);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> match_flag && ack);

    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag) |-> match_irq);

    p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !match_flag && !ack && !match_irq);

    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !match_flag && !match_irq);

    p_short_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq && !mode_10b |-> rx_addr[ADDR_W-1:7] == '0);

    p_capture_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !match_irq |-> $stable(rx_addr));
endmodule

bind i2c_masked_addr_filter i2c_amf_checker #(.ADDR_W(ADDR_W)) u_amf_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .bit_valid  (bit_valid),
    .mode_10b   (mode_10b),
    .ack        (ack),
    .match_irq  (match_irq),
    .match_flag (match_flag),
    .rx_addr    (rx_addr)
);

// File: tb/i2c_masked_addr_filter_tb_top.sv
module i2c_masked_addr_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       bit_valid = 1'b0;
    logic       bit_val = 1'b0;
    logic       mode_10b = 1'b0;
    logic [9:0] own_addr = '0;
    logic [4:0] addr_mask = '0;
    logic       ack;
    logic       match_irq;
    logic       match_flag;
    logic [9:0] rx_addr;
    logic       rx_rw;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2c_masked_addr_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .bit_valid  (bit_valid),
        .bit_val    (bit_val),
        .mode_10b   (mode_10b),
        .own_addr   (own_addr),
        .addr_mask  (addr_mask),
        .ack        (ack),
        .match_irq  (match_irq),
        .match_flag (match_flag),
        .rx_addr    (rx_addr),
        .rx_rw      (rx_rw)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       ten;
        logic [9:0] own;
        logic [4:0] msk;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       ack1;
        logic       hit;
        logic [9:0] rx;
        logic       rw;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  1'b0, 10'h0A0, 5'h07, 8'hAE, 8'h00, 1'b1, 1'b1, 10'h057, 1'b0},
        '{4'd1,  1'b0, 10'h0A0, 5'h07, 8'hB0, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd9,  1'b0, 10'h0A0, 5'h00, 8'hA1, 8'h00, 1'b1, 1'b1, 10'h050, 1'b1},
        '{4'd2,  1'b0, 10'h3A1, 5'h00, 8'hA0, 8'h00, 1'b1, 1'b1, 10'h050, 1'b0},
        '{4'd11, 1'b0, 10'h0A0, 5'h00, 8'hA2, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd1,  1'b0, 10'h0A0, 5'h1F, 8'h3E, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd1,  1'b0, 10'h0A0, 5'h1F, 8'hBE, 8'h00, 1'b1, 1'b1, 10'h05F, 1'b0},
        '{4'd1,  1'b0, 10'h0A0, 5'h01, 8'hA2, 8'h00, 1'b1, 1'b1, 10'h051, 1'b0},
        '{4'd1,  1'b0, 10'h0A0, 5'h01, 8'hA4, 8'h00, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h07, 8'hF4, 8'hAF, 1'b1, 1'b1, 10'h2AF, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h07, 8'hF4, 8'hB0, 1'b1, 1'b0, 10'h000, 1'b0},
        '{4'd3,  1'b1, 10'h2A0, 5'h07, 8'hF2, 8'hA0, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd9,  1'b1, 10'h2A0, 5'h00, 8'hF5, 8'hA0, 1'b1, 1'b1, 10'h2A0, 1'b1},
        '{4'd11, 1'b1, 10'h2A0, 5'h00, 8'hF4, 8'hA1, 1'b1, 1'b0, 10'h000, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h1F, 8'hF4, 8'hBF, 1'b1, 1'b1, 10'h2BF, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h1F, 8'hF4, 8'h60, 1'b1, 1'b0, 10'h000, 1'b0},
        '{4'd3,  1'b1, 10'h2A0, 5'h00, 8'hE4, 8'hA0, 1'b0, 1'b0, 10'h000, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h01, 8'hF4, 8'hA3, 1'b1, 1'b1, 10'h2A3, 1'b0},
        '{4'd4,  1'b1, 10'h2A0, 5'h01, 8'hF4, 8'hA4, 1'b1, 1'b0, 10'h000, 1'b0}
    };

    function automatic string tag(logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd9:    return "R9";
            4'd11:   return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask

    task automatic send_bit(logic b);
        @(negedge clk) begin bit_valid = 1'b1; bit_val = b; end
        @(negedge clk) bit_valid = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    // Acknowledge slot after a byte: one idle cycle, then the slot strobe.
    task automatic ack_slot(logic exp_ack, string req);
        @(negedge clk);
        check({req, " ack held"}, ack, exp_ack);
        check("R7 irq one cycle", match_irq, 1'b0);
        send_bit(1'b0);
        check("R5 ack released", ack, 1'b0);
    endtask

    task automatic run_vec(vec_t v);
        string t = tag(v.req);
        @(negedge clk) begin mode_10b = v.ten; own_addr = v.own; addr_mask = v.msk; end
        pulse_start();
        check("R8 flag after start", match_flag, 1'b0);
        send_byte(v.b1);
        if (!v.ten) begin
            check({t, " ack 7b"}, ack, v.hit);
            check("R7 irq 7b", match_irq, v.hit);
            if (v.hit) begin
                check("R9 rx_addr 7b", rx_addr, v.rx);
                check("R9 rx_rw 7b", rx_rw, v.rw);
            end
            ack_slot(v.hit, "R5");
        end else begin
            check({t, " ack hdr"}, ack, v.ack1);
            check("R7 no irq on hdr", match_irq, 1'b0);
            ack_slot(v.ack1, "R5");
            if (v.ack1) begin
                send_byte(v.b2);
                check({t, " ack low"}, ack, v.hit);
                check("R7 irq 10b", match_irq, v.hit);
                if (v.hit) begin
                    check("R9 rx_addr 10b", rx_addr, v.rx);
                    check("R9 rx_rw 10b", rx_rw, v.rw);
                end
                ack_slot(v.hit, "R5");
            end
        end
        check({t, " flag"}, match_flag, v.hit);
        pulse_stop();
        check("R8 flag after stop", match_flag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs held at zero during reset
        check("R10 ack", ack, 1'b0);
        check("R10 irq", match_irq, 1'b0);
        check("R10 flag", match_flag, 1'b0);
        check("R10 rx_addr", rx_addr, 10'h000);
        check("R10 rx_rw", rx_rw, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R10 ack after release", ack, 1'b0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R6: bits after a mismatch are ignored until the next start
        @(negedge clk) begin mode_10b = 1'b0; own_addr = 10'h0A0; addr_mask = 5'h00; end
        pulse_start();
        send_byte(8'h00);
        check("R6 no ack on miss", ack, 1'b0);
        send_bit(1'b0);
        send_byte(8'hA0);
        check("R6 ignored byte ack", ack, 1'b0);
        check("R6 ignored byte irq", match_irq, 1'b0);
        check("R6 ignored byte flag", match_flag, 1'b0);
        pulse_start();
        send_byte(8'hA0);
        check("R6 match after new start", ack, 1'b1);

        // R5: acknowledge held through a long wait for the slot strobe
        repeat (6) @(negedge clk);
        check("R5 ack held long", ack, 1'b1);
        send_bit(1'b0);
        check("R5 ack drop", ack, 1'b0);
        check("R7 flag kept", match_flag, 1'b1);

        // R8: a repeated start clears the flag
        pulse_start();
        check("R8 start clears flag", match_flag, 1'b0);

        // R8: a start in mid-byte restarts the bit count
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        pulse_start();
        send_byte(8'hA0);
        check("R8 restart mid-byte", ack, 1'b1);
        send_bit(1'b0);

        // R8: a stop during a 10-bit header acknowledge ends it
        @(negedge clk) begin mode_10b = 1'b1; own_addr = 10'h2A0; end
        pulse_start();
        send_byte(8'hF4);
        check("R3 header ack", ack, 1'b1);
        pulse_stop();
        check("R8 stop drops ack", ack, 1'b0);
        send_byte(8'hA0);
        check("R8 idle after stop", ack, 1'b0);
        check("R8 no irq after stop", match_irq, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule